// File: doc/BRIEF.md
# Strobe-Driven x16 DRAM Behavioural Model

This block is a synthesizable stand-in for the control logic of an asynchronous x16 dynamic memory. A fast simulation clock samples the row strobe, the two byte column strobes, the write enable and the output enable. From the order in which these strobes fall and rise, the block classifies every memory cycle. It latches row and column addresses, performs word or byte reads and writes into a small storage array, and keeps an internal refresh row counter. It drives the two data byte lanes with extended-data-out hold, so read data stays valid after the column strobe rises.

A DRAM controller under test connects to the strobe and address inputs. It drives write data on `dq_i` and sees read data on `dq_o`, with one enable bit per byte lane standing for the tri-state buffers. The `cyc_kind` output reports what the most recent strobe event was taken to mean. `ref_row` reports the row touched by the most recent refresh. A sticky flag marks any access attempted before the wake-up sequence has finished.

All outputs are registered. They change at the clock edge that first samples the strobe event that causes the change.

Top module: `strobe_dram_model`

## Requirements
- R1: When the row strobe and both column strobes are sampled high, `dq_oe` is 2'b00 after that clock edge.
- R2: The internal column strobe becomes active at the first byte strobe to fall, and the column address is latched only then. It stays active until the last byte strobe rises. A second byte strobe that falls later adds its lane to the same access and does not re-latch the column.
- R3: When the row strobe falls while at least one column strobe is low, the cycle is a counter refresh. `cyc_kind` becomes 6, the address pins are ignored, `ref_row` takes the internal counter value, and output lanes that were off stay off.
- R4: When the row strobe falls with both column strobes high and rises again before any column strobe falls, `cyc_kind` becomes 5 and `ref_row` takes the row address latched at the fall.
- R5: A read starts at the later of the column strobe falling or the output enable falling, with write enable high. `cyc_kind` becomes 2. `dq_o` carries the stored word. `dq_oe` bit 0 (lower byte, bits 7:0) follows the lower strobe and bit 1 (upper byte, bits 15:8) follows the upper strobe.
- R6: When write enable is low as the column strobe falls, the cycle is an early write. `cyc_kind` becomes 3, the byte lanes whose strobes are low are written from `dq_i`, and `dq_oe` stays 2'b00 for that column cycle.
- R7: When write enable falls while the column strobe is already low, the cycle is a late write. `cyc_kind` becomes 4, the data is written from `dq_i` at that edge, and the outputs turn off.
- R8: Read data stays driven after the column strobe rises, until the next column strobe fall. The outputs turn off when output enable is high, or when the row strobe and both column strobes are high.
- R9: When the column strobe stays low while the row strobe rises and falls again, the cycle is a hidden refresh. `cyc_kind` becomes 7 and the previous read data and lane enables stay on the outputs.
- R10: The refresh counter starts at 0 after reset and advances by one after each counter or hidden refresh, wrapping from 511 to 0.
- R11: Until eight row strobe falls have occurred since reset, any read or write attempt is blocked: nothing is written, no lane is driven, and `init_err` is set. `init_err` stays set until reset.
- R12: The storage array is addressed by the low 3 bits of the row and the low 3 bits of the column, so column 11 aliases column 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, much faster than the strobe edges |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower byte column strobe, active low |
| ucas_n | input | 1 | Upper byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 9 | Multiplexed row/column address |
| dq_i | input | 16 | Write data from the controller |
| dq_o | output | 16 | Read data toward the controller |
| dq_oe | output | 2 | Per-lane output drive enable (bit 1 upper byte) |
| cyc_kind | output | 3 | Classification of the latest strobe event |
| ref_row | output | 9 | Row refreshed by the latest refresh cycle |
| init_err | output | 1 | Sticky flag for an access before wake-up completed |

## Verification
The hardest state to reach is the hidden refresh. A read must already be driving, with the column strobe held low across a full rise and fall of the row strobe. The bench builds it on purpose: it opens a row, reads a word with output enable low, then toggles only the row strobe. It checks that the data and lane enables survive both edges while the class and the refresh row change. The counter wrap needs more than five hundred refresh cycles. These come from a loop of counter refresh tasks that checks every step until the value returns to zero.

// File: rtl/dram_strobe_pkg.sv
// Shared definitions for the strobe-driven DRAM model.
// Assumes: cycle classes fit in three bits; the numeric values are visible at the top-level port.
package dram_strobe_pkg;
    typedef enum logic [2:0] {
        KIND_NONE   = 3'd0,
        KIND_OPEN   = 3'd1,
        KIND_READ   = 3'd2,
        KIND_EWRITE = 3'd3,
        KIND_LWRITE = 3'd4,
        KIND_RONLY  = 3'd5,
        KIND_CBR    = 3'd6,
        KIND_HIDDEN = 3'd7
    } cyc_kind_e;
endpackage

// File: rtl/strobe_edges.sv
// Edge detector for the asynchronous strobes, sampled on the model clock.
// Merges the two byte column strobes into one internal column strobe:
// it is active while either byte strobe is low.
// Assumes: the strobes are already synchronous to clk (simulation model).
module strobe_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    input  logic lcas_n,
    input  logic ucas_n,
    input  logic we_n,
    output logic ras_fall,
    output logic ras_rise,
    output logic cas_act,
    output logic cas_fall,
    output logic we_fall
);
    logic ras_q, cas_q, we_q;

    assign cas_act  = ~(lcas_n & ucas_n);
    assign ras_fall = ras_q & ~ras_n;
    assign ras_rise = ~ras_q & ras_n;
    assign cas_fall = cas_act & ~cas_q;
    assign we_fall  = we_q & ~we_n;

    // Hold the previous sample of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ras_q <= 1'b1;
            cas_q <= 1'b0;
            we_q  <= 1'b1;
        end else begin
            ras_q <= ras_n;
            cas_q <= cas_act;
            we_q  <= we_n;
        end
    end
endmodule

// File: rtl/dram_refresh_ctr.sv
// Internal refresh row counter: advances once per counter-driven refresh, wraps at 2**W.
// Assumes: step is a single-cycle pulse.
module dram_refresh_ctr #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] cnt
);
    // Count refresh cycles modulo 2**W.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (step) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dram_word_store.sv
// Small storage array with one independent memory per byte lane.
// Read is combinational and write is synchronous with a per-lane enable.
// Assumes: no reset of contents; unwritten words read as unknown.
module dram_word_store #(
    parameter int AW     = 6,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    wr,
    input  logic [LANES-1:0]        lane_en,
    input  logic [AW-1:0]           addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        // Write this lane's byte when its strobe takes part in the write.
        always_ff @(posedge clk) begin
            if (wr && lane_en[g]) mem[addr] <= wdata[g*LANE_W +: LANE_W];
        end
        assign rdata[g*LANE_W +: LANE_W] = mem[addr];
    end
endmodule

// File: rtl/strobe_dram_model.sv
// Top of the DRAM model: classifies strobe cycles, latches addresses,
// runs reads and writes on the store, steers the per-lane output enables
// with extended data hold, and tracks the wake-up count.
// Assumes: every strobe level is held for at least one clk period.
module strobe_dram_model
    import dram_strobe_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 16,
    parameter int ROW_BITS    = 3,
    parameter int COL_BITS    = 3,
    parameter int INIT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic [1:0]        dq_oe,
    output logic [2:0]        cyc_kind,
    output logic [ADDR_W-1:0] ref_row,
    output logic              init_err
);
    localparam int LANES  = 2;
    localparam int LANE_W = DATA_W / LANES;
    localparam int SAW    = ROW_BITS + COL_BITS;
    localparam int ICW    = $clog2(INIT_CYCLES + 1);

    logic ras_fall, ras_rise, cas_act, cas_fall, we_fall;
    logic [ADDR_W-1:0] row_q, col_q, ref_cnt;
    logic row_open, cas_seen, cas_held, early_q;
    logic [ICW-1:0] init_cnt;
    logic [LANES-1:0] lanes, oe_q;
    logic [DATA_W-1:0] dout_q, rdata;
    cyc_kind_e kind_q;

    strobe_edges u_edges (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n),
        .ucas_n(ucas_n), .we_n(we_n), .ras_fall(ras_fall),
        .ras_rise(ras_rise), .cas_act(cas_act), .cas_fall(cas_fall),
        .we_fall(we_fall)
    );

    logic refresh_ev;
    assign refresh_ev = ras_fall & cas_act;

    dram_refresh_ctr #(.W(ADDR_W)) u_rctr (
        .clk(clk), .rst_n(rst_n), .step(refresh_ev), .cnt(ref_cnt)
    );

    // Access decode for the current sample.
    logic ready, acc_open, early_now, wr_try, rd_try, wr_do, rd_do;
    logic [ADDR_W-1:0] col_now;
    assign lanes     = ~{ucas_n, lcas_n};
    assign ready     = (init_cnt == ICW'(INIT_CYCLES));
    assign col_now   = cas_fall ? addr : col_q;
    assign early_now = cas_fall ? ~we_n : early_q;
    assign acc_open  = row_open & ~ras_n & cas_act;
    assign wr_try    = acc_open & ((cas_fall & ~we_n) | (we_fall & ~cas_fall));
    assign rd_try    = acc_open & we_n & ~oe_n & ~early_now;
    assign wr_do     = wr_try & ready;
    assign rd_do     = rd_try & ready;

    dram_word_store #(.AW(SAW), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk(clk), .wr(wr_do), .lane_en(lanes),
        .addr({row_q[ROW_BITS-1:0], col_now[COL_BITS-1:0]}),
        .wdata(dq_i), .rdata(rdata)
    );

    // Row/column latches and cycle bookkeeping flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q    <= '0;
            col_q    <= '0;
            row_open <= 1'b0;
            cas_seen <= 1'b0;
            cas_held <= 1'b0;
            early_q  <= 1'b0;
        end else begin
            if (ras_fall && !cas_act) row_q <= addr;
            if (ras_fall)             row_open <= ~cas_act;
            else if (ras_rise)        row_open <= 1'b0;
            if (ras_fall)                     cas_seen <= 1'b0;
            else if (row_open && cas_fall)    cas_seen <= 1'b1;
            if (!cas_act)                     cas_held <= 1'b0;
            else if (ras_rise)                cas_held <= 1'b1;
            if (cas_fall) begin
                col_q   <= addr;
                early_q <= ~we_n;
            end
        end
    end

    // Wake-up counter and sticky early-access flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_cnt <= '0;
            init_err <= 1'b0;
        end else begin
            if (ras_fall && !ready)            init_cnt <= init_cnt + 1'b1;
            if ((wr_try || rd_try) && !ready)  init_err <= 1'b1;
        end
    end

    // Output lanes with extended data hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q   <= '0;
            dout_q <= '0;
        end else if (wr_try || oe_n || (ras_n && !cas_act)) begin
            oe_q <= '0;
        end else if (rd_do) begin
            oe_q   <= cas_fall ? lanes : (oe_q | lanes);
            dout_q <= rdata;
        end else if (cas_fall) begin
            oe_q <= '0;
        end
    end

    // Cycle classification and refreshed-row report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= KIND_NONE;
            ref_row <= '0;
        end else if (refresh_ev) begin
            kind_q  <= cas_held ? KIND_HIDDEN : KIND_CBR;
            ref_row <= ref_cnt;
        end else if (ras_fall) begin
            kind_q <= KIND_OPEN;
        end else if (ras_rise && row_open && !cas_seen) begin
            kind_q  <= KIND_RONLY;
            ref_row <= row_q;
        end else if (wr_do) begin
            kind_q <= cas_fall ? KIND_EWRITE : KIND_LWRITE;
        end else if (rd_do) begin
            kind_q <= KIND_READ;
        end
    end

    assign dq_o     = dout_q;
    assign dq_oe    = oe_q;
    assign cyc_kind = kind_q;
endmodule

// File: rtl/strobe_dram_checker.sv
// Assertion checker for strobe_dram_model, attached by bind.
// Assumes: rst_n is held low for at least one clock at start.
module strobe_dram_checker
    import dram_strobe_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ras_n,
    input logic       lcas_n,
    input logic       ucas_n,
    input logic       oe_n,
    input logic [1:0] dq_oe,
    input logic [2:0] cyc_kind,
    input logic       init_err
);
    AST_STANDBY_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_n && lcas_n && ucas_n) |=> (dq_oe == 2'b00)); // R1

    AST_CBR_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !(lcas_n && ucas_n)) |=>
        (cyc_kind == KIND_CBR || cyc_kind == KIND_HIDDEN)); // R3

    AST_CBR_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ras_n) && !(lcas_n && ucas_n) && dq_oe == 2'b00) |=> (dq_oe == 2'b00)); // R3

    AST_EWRITE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_kind == KIND_EWRITE) |-> (dq_oe == 2'b00)); // R6

    AST_OE_HIGH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> (dq_oe == 2'b00)); // R8

    AST_INIT_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_err |=> init_err); // R11
endmodule

bind strobe_dram_model strobe_dram_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n),
    .ucas_n(ucas_n), .oe_n(oe_n), .dq_oe(dq_oe), .cyc_kind(cyc_kind),
    .init_err(init_err)
);

// File: tb/sim_strobe_dram_model.sv
`timescale 1ns/100ps
module sim_strobe_dram_model;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [8:0]  addr = '0;
    logic [15:0] dq_i = '0;
    logic [15:0] dq_o;
    logic [1:0]  dq_oe;
    logic [2:0]  cyc_kind;
    logic [8:0]  ref_row;
    logic        init_err;
    int n_run = 0, n_fail = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    strobe_dram_model u0 (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .dq_i(dq_i), .dq_o(dq_o),
        .dq_oe(dq_oe), .cyc_kind(cyc_kind), .ref_row(ref_row), .init_err(init_err)
    );

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; ras_n = 1; lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1;
        tick(); tick();
        rst_n = 1; tick();
        exp_cnt = 0;
    endtask

    task automatic open_row(input logic [8:0] r);
        addr = r; ras_n = 0; tick();
    endtask

    task automatic close_row();
        lcas_n = 1; ucas_n = 1; we_n = 1; oe_n = 1; tick();
        ras_n = 1; tick();
    endtask

    task automatic ewrite(input logic [8:0] c, input logic [15:0] d, input logic [1:0] ln);
        addr = c; dq_i = d; we_n = 0; lcas_n = ~ln[0]; ucas_n = ~ln[1]; tick();
        chk("R6 early write class", cyc_kind, 3);
        chk("R6 early write outputs off", dq_oe, 0);
        lcas_n = 1; ucas_n = 1; we_n = 1; tick();
    endtask

    task automatic rd(input logic [8:0] c, input logic [1:0] ln);
        addr = c; we_n = 1; oe_n = 0; lcas_n = ~ln[0]; ucas_n = ~ln[1]; tick();
    endtask

    task automatic cbr_one();
        lcas_n = 0; ucas_n = 0; addr = 9'h1FF; tick();
        ras_n = 0; tick();
        chk("R3 counter refresh class", cyc_kind, 6);
        chk("R10 refresh row from counter", ref_row, exp_cnt);
        chk("R3 outputs stay off", dq_oe, 0);
        exp_cnt = (exp_cnt + 1) % 512;
        ras_n = 1; tick();
        lcas_n = 1; ucas_n = 1; tick();
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 reset outputs off", dq_oe, 0);
        chk("R3 reset class", cyc_kind, 0);
        chk("R10 reset counter view", ref_row, 0);
        chk("R11 reset flag", init_err, 0);
    endtask

    task automatic t_early_access();
        open_row(9'd5);
        addr = 9'd3; dq_i = 16'hDEAD; we_n = 0; lcas_n = 0; ucas_n = 0; tick();
        chk("R11 write before wake-up flags", init_err, 1);
        chk("R11 blocked write keeps class", cyc_kind, 1);
        we_n = 1; oe_n = 0; lcas_n = 1; ucas_n = 1; tick();
        lcas_n = 0; ucas_n = 0; tick();
        chk("R11 blocked read drives nothing", dq_oe, 0);
        close_row();
        chk("R11 flag sticky", init_err, 1);
        do_reset();
        chk("R11 flag cleared by reset", init_err, 0);
    endtask

    task automatic t_wakeup();
        for (int i = 0; i < 8; i++) cbr_one();
    endtask

    task automatic t_page_write_read();
        open_row(9'd5);
        ewrite(9'd3, 16'hA5C3, 2'b11);
        ewrite(9'd4, 16'h0F1E, 2'b11);
        close_row();
        chk("R11 no flag after wake-up", init_err, 0);
        open_row(9'd5);
        rd(9'd3, 2'b11);
        chk("R5 read class", cyc_kind, 2);
        chk("R5 read data", dq_o, 16'hA5C3);
        chk("R5 both lanes on", dq_oe, 2'b11);
        lcas_n = 1; ucas_n = 1; tick();
        chk("R8 data held past CAS rise", dq_o, 16'hA5C3);
        chk("R8 lanes held past CAS rise", dq_oe, 2'b11);
        rd(9'd4, 2'b11);
        chk("R5 page read second column", dq_o, 16'h0F1E);
        oe_n = 1; tick();
        chk("R8 OE high turns off", dq_oe, 0);
        close_row();
        chk("R1 standby outputs off", dq_oe, 0);
    endtask

    task automatic t_oe_late();
        open_row(9'd5);
        addr = 9'd4; we_n = 1; oe_n = 1; lcas_n = 0; ucas_n = 0; tick();
        chk("R5 no drive before OE falls", dq_oe, 0);
        oe_n = 0; tick();
        chk("R5 read starts at OE fall", dq_oe, 2'b11);
        chk("R5 data at OE fall", dq_o, 16'h0F1E);
        close_row();
    endtask

    task automatic t_byte_access();
        open_row(9'd5);
        ewrite(9'd3, 16'h1234, 2'b01);
        close_row();
        open_row(9'd5);
        rd(9'd3, 2'b10);
        chk("R5 upper byte lane only", dq_oe, 2'b10);
        chk("R5 upper byte kept", dq_o[15:8], 8'hA5);
        lcas_n = 1; ucas_n = 1; tick();
        rd(9'd11, 2'b01);
        chk("R5 lower byte lane only", dq_oe, 2'b01);
        chk("R12 aliased column lower byte written", dq_o[7:0], 8'h34);
        close_row();
    endtask

    task automatic t_merge();
        open_row(9'd5);
        addr = 9'd3; we_n = 1; oe_n = 0; lcas_n = 0; tick();
        chk("R2 first strobe lane", dq_oe, 2'b01);
        addr = 9'd4; ucas_n = 0; tick();
        chk("R2 second strobe adds lane", dq_oe, 2'b11);
        chk("R2 column from first fall", dq_o, 16'hA534);
        lcas_n = 1; tick();
        chk("R2 active until last rise", dq_oe, 2'b11);
        close_row();
    endtask

    task automatic t_late_write();
        open_row(9'd6);
        addr = 9'd1; we_n = 1; oe_n = 1; lcas_n = 0; ucas_n = 0; tick();
        dq_i = 16'hBEEF; we_n = 0; tick();
        chk("R7 late write class", cyc_kind, 4);
        chk("R7 outputs off", dq_oe, 0);
        close_row();
        open_row(9'd6);
        rd(9'd1, 2'b11);
        chk("R7 late write data stored", dq_o, 16'hBEEF);
        close_row();
    endtask

    task automatic t_ras_only();
        open_row(9'h0AB);
        ras_n = 1; tick();
        chk("R4 row-only refresh class", cyc_kind, 5);
        chk("R4 refreshed row", ref_row, 9'h0AB);
        chk("R4 outputs off", dq_oe, 0);
    endtask

    task automatic t_hidden();
        open_row(9'd5);
        rd(9'd3, 2'b11);
        chk("R5 read before hidden", dq_o, 16'hA534);
        ras_n = 1; tick();
        chk("R9 data kept while row strobe high", dq_oe, 2'b11);
        addr = 9'h1F0; ras_n = 0; tick();
        chk("R9 hidden refresh class", cyc_kind, 7);
        chk("R9 lanes kept", dq_oe, 2'b11);
        chk("R9 data kept", dq_o, 16'hA534);
        chk("R10 hidden uses counter", ref_row, exp_cnt);
        exp_cnt = (exp_cnt + 1) % 512;
        close_row();
    endtask

    task automatic t_wrap();
        int rem;
        rem = 512 - exp_cnt + 1;
        for (int i = 0; i < rem; i++) cbr_one();
        chk("R10 counter wrapped", exp_cnt, 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset_state();
        t_early_access();
        t_wakeup();
        t_page_write_read();
        t_oe_late();
        t_byte_access();
        t_merge();
        t_late_write();
        t_ras_only();
        t_hidden();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule